// File: doc/BRIEF.md
# Reset Sequence Manager

This block merges three reset requests into one internal reset and then runs a fixed sequence. The requests are an external reset pin, a request from the low-voltage detector, and a watchdog underflow pulse. The sequence has three steps. An active step comes first. A stabilisation delay follows, and an option input sets its length. The last step is a two-cycle vector fetch that presents the two topmost code addresses. An open-drain pull-down on the reset pin is enabled for the whole active and delay steps. The pin is therefore low whatever caused the reset, and other devices on the board see the reset too.

The pin level is brought into the clock domain through a synchroniser. It is accepted as a reset only after it has stayed low for a minimum number of clock cycles, so short glitches are ignored. Two sticky cause flags tell software what caused the last reset. They follow asymmetric rules:
- The low-voltage flag survives later pin and watchdog resets.
- A low-voltage reset clears the watchdog flag.
- Software clears a flag by writing zero to its bit.

Every pin of the block is a plain level or pulse control signal. No data stream passes through it, so there is no valid/ready handshake and no back-pressure.

Top module: `reset_seq_mgr`

## Requirements
- R1: A low-voltage request, a watchdog underflow pulse or an accepted pin reset, seen while no sequence runs, starts a sequence in the next cycle. `int_rst_o` and `pin_pull_o` are both high for every cycle of the active and delay steps.
- R2: The pin counts as a reset when the synchronised pin is low at MIN_PULSE consecutive rising edges while no sequence runs. A low level seen at MIN_PULSE-1 edges is ignored. The pin is also ignored while a sequence runs, so holding it low then neither lengthens the sequence nor starts another one.
- R3: The active step lasts ACT_MIN cycles. It lasts longer while the low-voltage request stays high: after a request held for H edges it ends at edge max(ACT_MIN, H).
- R4: The delay step lasts DLY_LONG cycles when `opt_long_dly_i` is 1 and DLY_SHORT cycles when it is 0. The option is captured when the sequence starts, and a change during the sequence has no effect.
- R5: After the delay, `vec_fetch_o` is high for exactly two cycles with `vec_addr_o` equal to 16'hFFFE and then 16'hFFFF. `int_rst_o` and `pin_pull_o` are low during the fetch, and the block is idle afterwards.
- R6: A low-voltage or watchdog request during the delay step restarts the delay count from zero. A watchdog pulse at edge j of the sequence therefore gives j plus the delay length cycles of reset. A watchdog pulse during the active step restarts the active count.
- R7: `flag_lvd_o` is set by a low-voltage request. Only a write with `flag_clr_val_i[1]`=0 clears it. Pin and watchdog resets leave it unchanged.
- R8: `flag_wdg_o` is set by a watchdog pulse. It is cleared by a write with `flag_clr_val_i[0]`=0 or by a low-voltage request, and the clear wins if both arrive in the same cycle. Pin resets leave it unchanged.
- R9: A write carrying 1 in a bit leaves that flag unchanged. A hardware set in the same cycle as a software clear wins.
- R10: While `por_n` is low, `int_rst_o` and `pin_pull_o` are high, both flags are 0 and `vec_fetch_o` is 0. After release, a full sequence runs and ends in a vector fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_level_i | input | 1 | Level read back from the reset pin |
| lvd_req_i | input | 1 | Low-voltage reset request (level) |
| wdg_uflow_i | input | 1 | Watchdog underflow pulse |
| opt_long_dly_i | input | 1 | 1 selects the long stabilisation delay |
| flag_clr_we_i | input | 1 | Software write strobe for the cause flags |
| flag_clr_val_i | input | 2 | Write data: bit 1 LVD flag, bit 0 watchdog flag, 0 clears |
| int_rst_o | output | 1 | Internal reset, high in active and delay steps |
| pin_pull_o | output | 1 | Open-drain pull-down enable for the reset pin |
| vec_fetch_o | output | 1 | High during the two vector-fetch cycles |
| vec_addr_o | output | ADDR_W | Vector address during fetch, zero otherwise |
| flag_lvd_o | output | 1 | Sticky low-voltage cause flag |
| flag_wdg_o | output | 1 | Sticky watchdog cause flag |

## Verification
The bench drives pin pulses of exactly MIN_PULSE and MIN_PULSE-1 low edges. A filter that is off by one would either drop the first pulse or fire on the second. It also holds the pin low during a running sequence. A design that listened to the pin then would lengthen the sequence or start a second one, because its own pull-down reads back as low. Watchdog pulses land inside the active step and inside the delay step, and the bench checks the exact sequence length in each case, so a delay that does not restart, or that restarts from the wrong count, shows up as a wrong length. The flag tests cover a low-voltage reset after a watchdog reset, same-cycle set and clear, writes of one, and an option change in the middle of a sequence. A design with symmetric sticky rules or an option that is not captured would report the wrong cause or the wrong delay.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_DELAY  = 2'd2,
    PH_FETCH  = 2'd3
  } phase_e;
endpackage

// File: rtl/rsm_pin_filter.sv
module rsm_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_level_i,
  input  logic seq_idle_i,
  output logic ext_req_o
);
  localparam int PW = $clog2(MIN_PULSE + 1);
  localparam logic [PW-1:0] PMAX = PW'(MIN_PULSE - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [PW-1:0]          pcnt_q;
  logic                   low_s;

  // synchroniser chain, resets to the released (high) pin level
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= pin_level_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign low_s = ~sync_q[SYNC_STAGES-1];

  // width counter only runs while no sequence is active (R2)
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                     pcnt_q <= '0;
    else if (!seq_idle_i || !low_s) pcnt_q <= '0;
    else if (pcnt_q != PMAX)        pcnt_q <= pcnt_q + 1'b1;
  end

  assign ext_req_o = seq_idle_i && low_s && (pcnt_q == PMAX);

  generate
    if (MIN_PULSE > 1) begin : g_chk
      // R2: an accepted pin reset was already low on the previous cycle
      a_r2_pulse_width: assert property (@(posedge clk) disable iff (!por_n)
        ext_req_o |-> $past(low_s));
    end
  endgenerate
endmodule

// File: rtl/rsm_phase_ctl.sv
module rsm_phase_ctl
  import rsm_pkg::*;
#(
  parameter int          ACT_MIN   = 16,
  parameter int          DLY_LONG  = 4096,
  parameter int          DLY_SHORT = 256,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] VEC_BASE  = 16'hFFFE
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_req_i,
  input  logic              lvd_req_i,
  input  logic              wdg_pulse_i,
  input  logic              opt_long_i,
  output logic              int_rst_o,
  output logic              vec_fetch_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              seq_idle_o
);
  localparam int DMAX  = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
  localparam int CNT_W = $clog2(DMAX + 1);
  localparam int AW    = $clog2(ACT_MIN + 1);
  localparam logic [AW-1:0]    ALAST = AW'(ACT_MIN - 1);
  localparam logic [CNT_W-1:0] LLAST = CNT_W'(DLY_LONG - 1);
  localparam logic [CNT_W-1:0] SLAST = CNT_W'(DLY_SHORT - 1);

  phase_e           state_q, state_d;
  logic [AW-1:0]    acnt_q, acnt_d;
  logic [CNT_W-1:0] dcnt_q, dcnt_d;
  logic             fcnt_q, fcnt_d;
  logic             long_q, long_d;
  logic [CNT_W-1:0] dly_last;
  logic             hold_req;

  assign dly_last = long_q ? LLAST : SLAST;
  assign hold_req = lvd_req_i || wdg_pulse_i;

  always_comb begin
    state_d = state_q;
    acnt_d  = acnt_q;
    dcnt_d  = dcnt_q;
    fcnt_d  = fcnt_q;
    long_d  = long_q;
    unique case (state_q)
      PH_IDLE: begin
        if (hold_req || ext_req_i) begin
          state_d = PH_ACTIVE;
          acnt_d  = '0;
          long_d  = opt_long_i;
        end
      end
      PH_ACTIVE: begin
        if (wdg_pulse_i) begin
          acnt_d = '0;
        end else if (acnt_q == ALAST && !lvd_req_i) begin
          state_d = PH_DELAY;
          dcnt_d  = '0;
        end else if (acnt_q != ALAST) begin
          acnt_d = acnt_q + 1'b1;
        end
      end
      PH_DELAY: begin
        if (hold_req) begin
          dcnt_d = '0;
        end else if (dcnt_q == dly_last) begin
          state_d = PH_FETCH;
          fcnt_d  = 1'b0;
        end else begin
          dcnt_d = dcnt_q + 1'b1;
        end
      end
      PH_FETCH: begin
        if (hold_req) begin
          state_d = PH_ACTIVE;
          acnt_d  = '0;
          long_d  = opt_long_i;
        end else if (fcnt_q) begin
          state_d = PH_IDLE;
        end else begin
          fcnt_d = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= PH_ACTIVE;
      acnt_q  <= '0;
      dcnt_q  <= '0;
      fcnt_q  <= 1'b0;
      long_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      acnt_q  <= acnt_d;
      dcnt_q  <= dcnt_d;
      fcnt_q  <= fcnt_d;
      long_q  <= long_d;
    end
  end

  assign int_rst_o   = (state_q == PH_ACTIVE) || (state_q == PH_DELAY);
  assign vec_fetch_o = (state_q == PH_FETCH);
  assign seq_idle_o  = (state_q == PH_IDLE);
  assign vec_addr_o  = vec_fetch_o ? ADDR_W'({VEC_BASE[15:1], fcnt_q}) : '0;

  // independent run-length counter for the minimum sequence length check
  logic [31:0] run_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          run_q <= '0;
    else if (!int_rst_o)                 run_q <= '0;
    else if (run_q != 32'hFFFF_FFFF)     run_q <= run_q + 1'b1;
  end

  // R3/R4: a finished reset never ends early
  a_r3_min_run: assert property (@(posedge clk) disable iff (!por_n)
    $fell(int_rst_o) |-> (run_q >= 32'(ACT_MIN + DLY_SHORT)));

  // R5: first fetch cycle is followed by the second one
  a_r5_fetch_pair: assert property (@(posedge clk) disable iff (!por_n)
    (vec_fetch_o && !vec_addr_o[0] && !hold_req) |=> (vec_fetch_o && vec_addr_o[0]));

  // R5: fetch ends after its second cycle
  a_r5_fetch_end: assert property (@(posedge clk) disable iff (!por_n)
    (vec_fetch_o && vec_addr_o[0] && !hold_req) |=> (!vec_fetch_o && !int_rst_o));

  // R6: request during delay restarts the count
  a_r6_delay_restart: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == PH_DELAY && hold_req) |=> (state_q == PH_DELAY && dcnt_q == '0));

  // R4: delay selection frozen while reset is held
  a_r4_opt_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (int_rst_o && $past(int_rst_o)) |-> $stable(long_q));
endmodule

// File: rtl/rsm_cause_flags.sv
module rsm_cause_flags (
  input  logic       clk,
  input  logic       por_n,
  input  logic       lvd_req_i,
  input  logic       wdg_pulse_i,
  input  logic       clr_we_i,
  input  logic [1:0] clr_val_i,
  output logic       flag_lvd_o,
  output logic       flag_wdg_o
);
  logic lvd_q, wdg_q;
  logic clr_lvd, clr_wdg;

  assign clr_lvd = clr_we_i && !clr_val_i[1];
  assign clr_wdg = clr_we_i && !clr_val_i[0];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lvd_q <= 1'b0;
      wdg_q <= 1'b0;
    end else begin
      if (lvd_req_i)    lvd_q <= 1'b1;
      else if (clr_lvd) lvd_q <= 1'b0;

      if (lvd_req_i)        wdg_q <= 1'b0;
      else if (wdg_pulse_i) wdg_q <= 1'b1;
      else if (clr_wdg)     wdg_q <= 1'b0;
    end
  end

  assign flag_lvd_o = lvd_q;
  assign flag_wdg_o = wdg_q;

  a_r7_lvd_sets: assert property (@(posedge clk) disable iff (!por_n)
    lvd_req_i |=> flag_lvd_o);

  a_r7_lvd_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (flag_lvd_o && !clr_lvd) |=> flag_lvd_o);

  a_r8_lvd_clears_wdg: assert property (@(posedge clk) disable iff (!por_n)
    lvd_req_i |=> !flag_wdg_o);

  a_r9_wdg_set_wins: assert property (@(posedge clk) disable iff (!por_n)
    (wdg_pulse_i && !lvd_req_i) |=> flag_wdg_o);
endmodule

// File: rtl/reset_seq_mgr.sv
module reset_seq_mgr #(
  parameter int          SYNC_STAGES = 2,
  parameter int          MIN_PULSE   = 8,
  parameter int          ACT_MIN     = 16,
  parameter int          DLY_LONG    = 4096,
  parameter int          DLY_SHORT   = 256,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] VEC_BASE    = 16'hFFFE
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pin_level_i,
  input  logic              lvd_req_i,
  input  logic              wdg_uflow_i,
  input  logic              opt_long_dly_i,
  input  logic              flag_clr_we_i,
  input  logic [1:0]        flag_clr_val_i,
  output logic              int_rst_o,
  output logic              pin_pull_o,
  output logic              vec_fetch_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              flag_lvd_o,
  output logic              flag_wdg_o
);
  logic ext_req;
  logic seq_idle;
  logic rst_int;

  rsm_pin_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_PULSE   (MIN_PULSE)
  ) u_filter (
    .clk         (clk),
    .por_n       (por_n),
    .pin_level_i (pin_level_i),
    .seq_idle_i  (seq_idle),
    .ext_req_o   (ext_req)
  );

  rsm_phase_ctl #(
    .ACT_MIN   (ACT_MIN),
    .DLY_LONG  (DLY_LONG),
    .DLY_SHORT (DLY_SHORT),
    .ADDR_W    (ADDR_W),
    .VEC_BASE  (VEC_BASE)
  ) u_phase (
    .clk         (clk),
    .por_n       (por_n),
    .ext_req_i   (ext_req),
    .lvd_req_i   (lvd_req_i),
    .wdg_pulse_i (wdg_uflow_i),
    .opt_long_i  (opt_long_dly_i),
    .int_rst_o   (rst_int),
    .vec_fetch_o (vec_fetch_o),
    .vec_addr_o  (vec_addr_o),
    .seq_idle_o  (seq_idle)
  );

  rsm_cause_flags u_flags (
    .clk         (clk),
    .por_n       (por_n),
    .lvd_req_i   (lvd_req_i),
    .wdg_pulse_i (wdg_uflow_i),
    .clr_we_i    (flag_clr_we_i),
    .clr_val_i   (flag_clr_val_i),
    .flag_lvd_o  (flag_lvd_o),
    .flag_wdg_o  (flag_wdg_o)
  );

  assign int_rst_o  = rst_int;
  assign pin_pull_o = rst_int;

  // R1: the pin is never pulled while the vector is fetched
  a_r1_no_pull_in_fetch: assert property (@(posedge clk) disable iff (!por_n)
    vec_fetch_o |-> !pin_pull_o);
endmodule

// File: tb/reset_seq_mgr_bench.sv
module reset_seq_mgr_bench;
  localparam int MINP = 4;
  localparam int ACT  = 6;
  localparam int DL   = 40;
  localparam int DS   = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        por_n = 1'b0;
  logic        ext_drive = 1'b0;
  logic        lvd = 1'b0, wdg = 1'b0, opt = 1'b0;
  logic        clr_we = 1'b0;
  logic [1:0]  clr_val = 2'b11;
  logic        int_rst, pin_pull, vfetch, fl_lvd, fl_wdg;
  logic [15:0] vaddr;
  wire         pin_level = ~(ext_drive | pin_pull);

  reset_seq_mgr #(
    .MIN_PULSE(MINP), .ACT_MIN(ACT), .DLY_LONG(DL), .DLY_SHORT(DS)
  ) u_reset_seq_mgr (
    .clk(clk), .por_n(por_n), .pin_level_i(pin_level), .lvd_req_i(lvd),
    .wdg_uflow_i(wdg), .opt_long_dly_i(opt), .flag_clr_we_i(clr_we),
    .flag_clr_val_i(clr_val), .int_rst_o(int_rst), .pin_pull_o(pin_pull),
    .vec_fetch_o(vfetch), .vec_addr_o(vaddr), .flag_lvd_o(fl_lvd),
    .flag_wdg_o(fl_wdg)
  );

  int total = 0, bad = 0, hi_total = 0;
  bit eL = 1'b0, eW = 1'b0;

  always @(negedge clk) if (int_rst) hi_total++;

  function automatic int dly(bit o);
    return o ? DL : DS;
  endfunction
  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_flags(string req);
    chk(fl_lvd == eL, req, "lvd flag", int'(fl_lvd), int'(eL));
    chk(fl_wdg == eW, req, "wdg flag", int'(fl_wdg), int'(eW));
  endtask

  task automatic run_seq(int base, int exp_len, string req);
    int guard = 0;
    while (!vfetch && guard < 3000) begin step(); guard++; end
    chk(vfetch, req, "fetch reached", int'(vfetch), 1);
    if (exp_len >= 0) chk(hi_total - base == exp_len, req, "reset length", hi_total - base, exp_len);
    chk(vaddr == 16'hFFFE && !int_rst && !pin_pull, "R5", "fetch 1 addr", int'(vaddr), 16'hFFFE);
    step();
    chk(vfetch && vaddr == 16'hFFFF, "R5", "fetch 2 addr", int'(vaddr), 16'hFFFF);
    step();
    chk(!vfetch && !int_rst, "R5", "idle after fetch", int'({vfetch, int_rst}), 0);
    chk_flags(req);
  endtask

  task automatic lvd_seq(int hold, bit o, string req);
    int base = hi_total;
    opt = o; lvd = 1'b1;
    repeat (hold) step();
    lvd = 1'b0; eL = 1'b1; eW = 1'b0;
    run_seq(base, max2(ACT, hold) + dly(o), req);
  endtask

  task automatic wdg_seq(bit o, string req);
    int base = hi_total;
    opt = o; wdg = 1'b1; step(); wdg = 1'b0; eW = 1'b1;
    chk(int_rst && pin_pull, "R1", "pull on wdg", int'({int_rst, pin_pull}), 3);
    run_seq(base, ACT + dly(o), req);
  endtask

  task automatic ext_seq(int n, bit o, string req);
    int base = hi_total;
    int guard = 0;
    opt = o; ext_drive = 1'b1;
    repeat (n) step();
    ext_drive = 1'b0;
    while (!int_rst && guard < 20) begin step(); guard++; end
    chk(int_rst && pin_pull, req, "pin reset accepted", int'(int_rst), 1);
    run_seq(base, ACT + dly(o), req);
  endtask

  task automatic sw_clear(logic [1:0] v, string req);
    clr_we = 1'b1; clr_val = v; step(); clr_we = 1'b0; clr_val = 2'b11;
    if (!v[1]) eL = 1'b0;
    if (!v[0]) eW = 1'b0;
    chk_flags(req);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: run hung actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    // R10 power-on state
    step(); step(); step();
    chk(int_rst && pin_pull && !vfetch, "R10", "por outputs", int'({int_rst, pin_pull, vfetch}), 6);
    chk_flags("R10");
    por_n = 1'b1;
    run_seq(hi_total, -1, "R10");

    // R1 R3 R4 R7 basic low-voltage sequences
    lvd_seq(1, 1'b0, "R1");
    lvd_seq(1, 1'b1, "R4");
    lvd_seq(ACT + 4, 1'b0, "R3");
    // R8 watchdog after lvd keeps lvd flag
    wdg_seq(1'b0, "R7");
    // R8 lvd clears watchdog flag
    lvd_seq(2, 1'b0, "R8");
    // R2 exact threshold accepted, one short rejected
    ext_seq(MINP, 1'b0, "R2");
    base = hi_total;
    ext_drive = 1'b1; repeat (MINP - 1) step(); ext_drive = 1'b0;
    repeat (12) step();
    chk(hi_total == base, "R2", "short pulse ignored", hi_total - base, 0);
    chk_flags("R2");

    // R2 pin ignored during a running sequence
    base = hi_total;
    opt = 1'b0; lvd = 1'b1; step(); lvd = 1'b0;
    ext_drive = 1'b1; repeat (8) step(); ext_drive = 1'b0;
    run_seq(base, ACT + DS, "R2");
    base = hi_total;
    repeat (12) step();
    chk(hi_total == base, "R2", "no retrigger", hi_total - base, 0);

    // R4 option change mid-sequence ignored
    base = hi_total;
    opt = 1'b1; lvd = 1'b1; step(); lvd = 1'b0;
    repeat (3) step(); opt = 1'b0;
    run_seq(base, ACT + DL, "R4");

    // R6 watchdog in delay restarts delay (edge j = ACT+5)
    base = hi_total;
    opt = 1'b0; lvd = 1'b1; step(); lvd = 1'b0;
    repeat (ACT + 4) step();
    wdg = 1'b1; step(); wdg = 1'b0; eW = 1'b1;
    run_seq(base, ACT + 5 + DS, "R6");
    // R6 watchdog in active restarts active (edge j = 3)
    base = hi_total;
    lvd = 1'b1; step(); lvd = 1'b0; eL = 1'b1; eW = 1'b0;
    repeat (2) step();
    wdg = 1'b1; step(); wdg = 1'b0; eW = 1'b1;
    run_seq(base, 3 + ACT + DS, "R6");

    // R9 writes of one have no effect, zero clears
    sw_clear(2'b11, "R9");
    sw_clear(2'b10, "R8");
    sw_clear(2'b01, "R7");
    // R9 hardware set wins over same-cycle clear
    base = hi_total;
    wdg = 1'b1; clr_we = 1'b1; clr_val = 2'b00; step();
    wdg = 1'b0; clr_we = 1'b0; clr_val = 2'b11; eW = 1'b1; eL = 1'b0;
    chk_flags("R9");
    run_seq(base, ACT + DS, "R9");
    // R8 lvd and watchdog together leave watchdog flag clear
    base = hi_total;
    lvd = 1'b1; wdg = 1'b1; step(); lvd = 1'b0; wdg = 1'b0;
    eL = 1'b1; eW = 1'b0;
    chk_flags("R8");
    run_seq(base, ACT + DS, "R8");

    // constrained random mix
    for (int i = 0; i < 30; i++) begin
      int  kind = int'($urandom % 3);
      bit  o    = 1'($urandom % 2);
      case (kind)
        0: lvd_seq(1 + int'($urandom % 10), o, "R3");
        1: wdg_seq(o, "R8");
        default: ext_seq(MINP + int'($urandom % 4), o, "R2");
      endcase
      if ($urandom % 2 == 0) sw_clear(2'($urandom % 4), "R9");
      repeat (int'($urandom % 4)) step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule